// File: doc/BRIEF.md
# Halfword Stream to Full-Width Burst Writer

This block takes a stream of 16-bit halfwords and writes them to memory through an AXI4 write master with a 32-bit data bus. Software-side logic hands it a start address, which only has to be 2-byte aligned, and a halfword count, then pulses a start strobe. Halfwords arrive on a valid/ready stream. They are paired into 32-bit beats and held in a small buffer until a burst's worth is ready.

Every burst uses the full 4-byte beat size and incrementing addressing. A start address that sits in the middle of a word, or a count that ends in the middle of a word, is handled by dropping byte strobes on the first or last beat only. A burst is issued once the buffer holds a full burst, or once everything still owed is buffered. No burst crosses a 4 KB page. When the last write response has come back, the block pulses a done signal and reports whether any response carried an error.

Top module: `hsw_burst_writer`

## Requirements
- R1: A halfword that lands at a 4-byte aligned address goes on wData[15:0], and the halfword that follows it goes on wData[31:16]. Halfword i of a transfer is therefore written to byte addresses start+2i (low byte) and start+2i+1 (high byte).
- R2: Every write address carries awSize = 3'b010 (4 bytes), awBurst = 2'b01 (incrementing) and an address with bits [1:0] equal to zero.
- R3: When start address bit 1 is set, the first beat has wStrb = 4'b1100 and carries the first halfword on wData[31:16]. Every beat's strobe is 4'b1111, 4'b1100 or 4'b0011.
- R4: When the start offset plus the count is odd in halfwords, the last beat has wStrb = 4'b0011. All other beats, apart from the one covered by R3, have wStrb = 4'b1111.
- R5: A transfer uses ceil((count + startAddr[1]) / 2) beats. A burst holds at most 16 beats, awLen is its beat count minus one, and a burst shorter than 16 beats happens only at the tail of a transfer or at a page edge.
- R6: No burst crosses a 4096-byte address boundary. A transfer that reaches one is split there, and the next burst starts on the boundary.
- R7: inReady is low whenever the 16-entry beat buffer is full. While the first burst's address is being held off, exactly 32 halfwords are accepted.
- R8: done is high for exactly one cycle after the last write response. err is set by any response other than 2'b00, stays set until the next start, and is cleared by that start.
- R9: A start with a count of zero issues no write address and still produces one done pulse.
- R10: awValid, awAddr and awLen stay unchanged while awReady is low. wValid, wData, wStrb and wLast stay unchanged while wReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 1 | Starts a transfer; only sampled while idle |
| cfgAddr | input | ADDR_W | Byte start address, bit 0 zero |
| cfgCount | input | CNT_W | Number of halfwords to write |
| inData | input | 16 | Stream halfword |
| inValid | input | 1 | Stream data valid |
| inReady | output | 1 | Stream data accepted when high with inValid |
| awAddr | output | ADDR_W | Burst start address |
| awLen | output | 8 | Beats in burst minus one |
| awSize | output | 3 | Beat size code, always 4 bytes |
| awBurst | output | 2 | Burst type, always incrementing |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address accepted |
| wData | output | 32 | Write beat data |
| wStrb | output | 4 | Byte enables of the beat |
| wLast | output | 1 | Final beat of a burst |
| wValid | output | 1 | Write beat valid |
| wReady | input | 1 | Write beat accepted |
| bResp | input | 2 | Write response code |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Always ready for responses |
| done | output | 1 | One-cycle pulse at transfer end |
| err | output | 1 | Sticky error flag for the current transfer |
| busy | output | 1 | High from start until done |

## Verification
The assertions check the rules that hold on every single cycle. Each issued address must have full beat size, incrementing type and a word-aligned value. A burst must stay under the 16-beat cap and inside its 4 KB page. Strobes must take one of the three legal shapes. Address and data must hold steady under backpressure. The stream must never be accepted into a full buffer, and done must never last two cycles. The bench scenarios are needed for the things that only show across a whole transfer: lane order and byte placement in memory, which beat gets the partial strobes, how the transfer is cut into bursts at 16 beats and at page edges, the exact halfword count accepted while stalled, the zero-count case, and how the error flag is set and then cleared.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  localparam logic [2:0] SIZE_WORD  = 3'b010;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  // strobes from the burst control to the pack/buffer datapath
  typedef struct packed {
    logic start;  // load a new transfer
    logic pop;    // one beat leaves the buffer
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_ADDR,
    S_DATA,
    S_DRAIN
  } ctlState_t;

endpackage

// File: rtl/hsw_pack_buf.sv
module hsw_pack_buf
  import hsw_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BUF_DEPTH = 16,
  localparam int PTR_W    = $clog2(BUF_DEPTH),
  localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             startLane,
  input  logic [15:0]      inData,
  input  logic             inValid,
  output logic             inReady,
  output logic [31:0]      headData,
  output logic [3:0]       headStrb,
  output logic [LVL_W-1:0] level
);

  logic [CNT_W-1:0] hwLeft;
  logic             lane;       // 0: next halfword fills bits 15:0
  logic [15:0]      holdData;
  logic             holdValid;

  logic [31:0] bufData [BUF_DEPTH];
  logic [3:0]  bufStrb [BUF_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  logic        accept;
  logic        push;
  logic [31:0] pushData;
  logic [3:0]  pushStrb;
  logic        lastHw;

  assign inReady = (hwLeft != '0) && (level != LVL_W'(BUF_DEPTH));
  assign accept  = inValid && inReady;
  assign lastHw  = (hwLeft == CNT_W'(1));

  // beat assembly
  always_comb begin
    push     = 1'b0;
    pushData = '0;
    pushStrb = '0;
    if (accept) begin
      if (!lane) begin
        if (lastHw) begin
          push     = 1'b1;
          pushData = {16'h0000, inData};
          pushStrb = 4'b0011;
        end
      end else begin
        push     = 1'b1;
        pushData = {inData, holdValid ? holdData : 16'h0000};
        pushStrb = {2'b11, holdValid ? 2'b11 : 2'b00};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwLeft    <= '0;
      lane      <= 1'b0;
      holdData  <= '0;
      holdValid <= 1'b0;
    end else if (ctl.start) begin
      hwLeft    <= cfgCount;
      lane      <= startLane;
      holdValid <= 1'b0;
    end else if (accept) begin
      hwLeft <= hwLeft - CNT_W'(1);
      if (!lane) begin
        if (!lastHw) begin
          holdData  <= inData;
          holdValid <= 1'b1;
          lane      <= 1'b1;
        end
      end else begin
        holdValid <= 1'b0;
        lane      <= 1'b0;
      end
    end
  end

  // beat buffer
  always_ff @(posedge clk) begin
    if (push) begin
      bufData[wrPtr] <= pushData;
      bufStrb[wrPtr] <= pushStrb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push)    wrPtr <= wrPtr + PTR_W'(1);
      if (ctl.pop) rdPtr <= rdPtr + PTR_W'(1);
      case ({push, ctl.pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign headData = bufData[rdPtr];
  assign headStrb = bufStrb[rdPtr];

endmodule

// File: rtl/hsw_burst_ctl.sv
module hsw_burst_ctl
  import hsw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int MAX_BEATS  = 16,
  parameter int LVL_W      = 5,
  parameter int PAGE_BYTES = 4096,
  localparam int WA_W       = ADDR_W - 2,
  localparam int PAGE_WORDS = PAGE_BYTES / 4,
  localparam int PAGE_W     = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStart,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [LVL_W-1:0]  level,
  input  logic [31:0]       headData,
  input  logic [3:0]        headStrb,
  output dpCtl_t            ctl,
  output logic [ADDR_W-1:0] awAddr,
  output logic [7:0]        awLen,
  output logic [2:0]        awSize,
  output logic [1:0]        awBurst,
  output logic              awValid,
  input  logic              awReady,
  output logic [31:0]       wData,
  output logic [3:0]        wStrb,
  output logic              wLast,
  output logic              wValid,
  input  logic              wReady,
  input  logic [1:0]        bResp,
  input  logic              bValid,
  output logic              bReady,
  output logic              done,
  output logic              err,
  output logic              busy
);

  ctlState_t        state;
  logic [WA_W-1:0]  wordAddr;
  logic [CNT_W-1:0] beatsLeft;
  logic [8:0]       burstLen;
  logic [8:0]       beatIdx;
  logic [CNT_W-1:0] outstanding;

  logic [31:0] lenNow, toPage, startBeats;
  logic        takeStart, awFire, bFire, lastPop;

  assign takeStart = cfgStart && (state == S_IDLE);
  assign awFire    = awValid && awReady;
  assign bFire     = bValid && bReady;

  // beats the next burst may carry: tail, cap and page edge
  always_comb begin
    toPage = 32'(PAGE_WORDS) - 32'(wordAddr[PAGE_W-1:0]);
    lenNow = 32'(beatsLeft);
    if (lenNow > 32'(MAX_BEATS)) lenNow = 32'(MAX_BEATS);
    if (lenNow > toPage)         lenNow = toPage;
  end

  always_comb begin
    if (cfgCount == '0) startBeats = '0;
    else startBeats = (32'(cfgCount) + 32'(cfgAddr[1]) + 32'd1) >> 1;
  end

  assign ctl.start = takeStart;
  assign ctl.pop   = wValid && wReady;

  assign awValid = (state == S_ADDR);
  assign awAddr  = {wordAddr, 2'b00};
  assign awLen   = 8'(burstLen - 9'd1);
  assign awSize  = SIZE_WORD;
  assign awBurst = BURST_INCR;

  assign wValid  = (state == S_DATA);
  assign wData   = headData;
  assign wStrb   = headStrb;
  assign wLast   = (beatIdx == burstLen - 9'd1);
  assign lastPop = ctl.pop && wLast;

  assign bReady  = 1'b1;
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      wordAddr  <= '0;
      beatsLeft <= '0;
      burstLen  <= '0;
      beatIdx   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (takeStart) begin
            wordAddr  <= cfgAddr[ADDR_W-1:2];
            beatsLeft <= CNT_W'(startBeats);
            state     <= (startBeats == '0) ? S_DRAIN : S_WAIT;
          end
        end
        S_WAIT: begin
          if (32'(level) >= lenNow) begin
            burstLen <= 9'(lenNow);
            state    <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (awFire) begin
            beatIdx <= '0;
            state   <= S_DATA;
          end
        end
        S_DATA: begin
          if (ctl.pop) beatIdx <= beatIdx + 9'd1;
          if (lastPop) begin
            wordAddr  <= wordAddr + WA_W'(burstLen);
            beatsLeft <= beatsLeft - CNT_W'(burstLen);
            state     <= (beatsLeft == CNT_W'(burstLen)) ? S_DRAIN : S_WAIT;
          end
        end
        S_DRAIN: begin
          if (outstanding == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // responses still owed, and the sticky error
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= '0;
      err         <= 1'b0;
    end else begin
      case ({awFire, bFire})
        2'b10:   outstanding <= outstanding + CNT_W'(1);
        2'b01:   outstanding <= outstanding - CNT_W'(1);
        default: outstanding <= outstanding;
      endcase
      if (takeStart) err <= 1'b0;
      else if (bFire && bResp != RESP_OKAY) err <= 1'b1;
    end
  end

endmodule

// File: rtl/hsw_burst_writer.sv
module hsw_burst_writer
  import hsw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MAX_BEATS = 16,
  parameter int BUF_DEPTH = 16,
  localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStart,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [15:0]       inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [ADDR_W-1:0] awAddr,
  output logic [7:0]        awLen,
  output logic [2:0]        awSize,
  output logic [1:0]        awBurst,
  output logic              awValid,
  input  logic              awReady,
  output logic [31:0]       wData,
  output logic [3:0]        wStrb,
  output logic              wLast,
  output logic              wValid,
  input  logic              wReady,
  input  logic [1:0]        bResp,
  input  logic              bValid,
  output logic              bReady,
  output logic              done,
  output logic              err,
  output logic              busy
);

  dpCtl_t           dpCtl;
  logic [31:0]      headData;
  logic [3:0]       headStrb;
  logic [LVL_W-1:0] bufLevel;

  hsw_pack_buf #(
    .CNT_W     (CNT_W),
    .BUF_DEPTH (BUF_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .cfgCount  (cfgCount),
    .startLane (cfgAddr[1]),
    .inData    (inData),
    .inValid   (inValid),
    .inReady   (inReady),
    .headData  (headData),
    .headStrb  (headStrb),
    .level     (bufLevel)
  );

  hsw_burst_ctl #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .MAX_BEATS (MAX_BEATS),
    .LVL_W     (LVL_W)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgStart (cfgStart),
    .cfgAddr  (cfgAddr),
    .cfgCount (cfgCount),
    .level    (bufLevel),
    .headData (headData),
    .headStrb (headStrb),
    .ctl      (dpCtl),
    .awAddr   (awAddr),
    .awLen    (awLen),
    .awSize   (awSize),
    .awBurst  (awBurst),
    .awValid  (awValid),
    .awReady  (awReady),
    .wData    (wData),
    .wStrb    (wStrb),
    .wLast    (wLast),
    .wValid   (wValid),
    .wReady   (wReady),
    .bResp    (bResp),
    .bValid   (bValid),
    .bReady   (bReady),
    .done     (done),
    .err      (err),
    .busy     (busy)
  );

endmodule

// File: rtl/hsw_burst_writer_chk.sv
module hsw_burst_writer_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 16,
  parameter int BUF_DEPTH = 16,
  localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic [LVL_W-1:0]  bufLevel,
  input logic [ADDR_W-1:0] awAddr,
  input logic [7:0]        awLen,
  input logic [2:0]        awSize,
  input logic [1:0]        awBurst,
  input logic              awValid,
  input logic              awReady,
  input logic [31:0]       wData,
  input logic [3:0]        wStrb,
  input logic              wLast,
  input logic              wValid,
  input logic              wReady,
  input logic              done
);

  p_full_size_r2: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> (awSize == 3'b010 && awBurst == 2'b01 && awAddr[1:0] == 2'b00));

  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> (32'(awLen) < 32'(MAX_BEATS)));

  p_page_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> ((11'(awAddr[11:2]) + 11'(awLen)) < 11'd1024));

  p_strb_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> (wStrb == 4'b1111 || wStrb == 4'b1100 || wStrb == 4'b0011));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (32'(bufLevel) == 32'(BUF_DEPTH)) |-> !inReady);

  p_aw_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) |=> (awValid && $stable(awAddr) && $stable(awLen)));

  p_w_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && !wReady) |=> (wValid && $stable(wData) && $stable(wStrb) && $stable(wLast)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind hsw_burst_writer hsw_burst_writer_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_BEATS (MAX_BEATS),
  .BUF_DEPTH (BUF_DEPTH)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .bufLevel (bufLevel),
  .awAddr   (awAddr),
  .awLen    (awLen),
  .awSize   (awSize),
  .awBurst  (awBurst),
  .awValid  (awValid),
  .awReady  (awReady),
  .wData    (wData),
  .wStrb    (wStrb),
  .wLast    (wLast),
  .wValid   (wValid),
  .wReady   (wReady),
  .done     (done)
);

// File: tb/sim_hsw_burst_writer.sv
module sim_hsw_burst_writer;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        cfgStart;
  logic [31:0] cfgAddr;
  logic [15:0] cfgCount;
  logic [15:0] inData;
  logic        inValid, inReady;
  logic [31:0] awAddr;
  logic [7:0]  awLen;
  logic [2:0]  awSize;
  logic [1:0]  awBurst;
  logic        awValid, awReady;
  logic [31:0] wData;
  logic [3:0]  wStrb;
  logic        wLast, wValid, wReady;
  logic [1:0]  bResp;
  logic        bValid, bReady;
  logic        done, err, busy;

  hsw_burst_writer u0 (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgAddr(cfgAddr), .cfgCount(cfgCount),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .awAddr(awAddr), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
    .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wLast(wLast), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .done(done), .err(err), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // stream source
  logic        srcOn = 1'b0;
  int          srcN = 0, srcIdx = 0;
  logic [15:0] srcBase = '0;
  assign inValid = srcOn && (srcIdx < srcN);
  assign inData  = srcBase + 16'(srcIdx);

  // memory-side responder
  logic        awStall = 1'b0, wStall = 1'b0, errFirst = 1'b0, tick = 1'b0;
  logic [7:0]  mem [0:8191];
  logic [31:0] curA = '0;
  logic [31:0] awAddrLog [0:7];
  logic [7:0]  awLenLog  [0:7];
  int          awN = 0, wBeats = 0, bPend = 0, bDone = 0, doneN = 0, badAw = 0;
  logic [3:0]  firstStrb = '0, lastStrb = '0;

  assign awReady = !awStall;
  assign wReady  = !wStall || tick;
  assign bValid  = (bPend != 0);
  assign bResp   = (errFirst && bDone == 0) ? 2'b10 : 2'b00;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    tick   <= ~tick;
    if (awValid && awReady) begin
      if (awN < 8) begin
        awAddrLog[awN] <= awAddr;
        awLenLog[awN]  <= awLen;
      end
      if (awSize != 3'b010 || awBurst != 2'b01 || awAddr[1:0] != 2'b00) badAw <= badAw + 1;
      awN  <= awN + 1;
      curA <= awAddr;
    end
    if (wValid && wReady) begin
      for (int k = 0; k < 4; k++)
        if (wStrb[k]) mem[13'(curA + 32'(k))] <= wData[8*k +: 8];
      curA <= curA + 32'd4;
      if (wBeats == 0) firstStrb <= wStrb;
      lastStrb <= wStrb;
      wBeats   <= wBeats + 1;
    end
    bPend <= bPend + ((wValid && wReady && wLast) ? 1 : 0) - ((bValid && bReady) ? 1 : 0);
    if (bValid && bReady) bDone <= bDone + 1;
    if (done) doneN <= doneN + 1;
    if (inValid && inReady) srcIdx <= srcIdx + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
  endtask

  task automatic startXfer(input logic [31:0] addr, input int count, input logic [15:0] base);
    @(negedge clk);
    clearMem();
    awN = 0; wBeats = 0; bDone = 0; doneN = 0; badAw = 0;
    srcIdx = 0; srcN = count; srcBase = base; srcOn = 1'b1;
    cfgAddr = addr; cfgCount = 16'(count); cfgStart = 1'b1;
    @(negedge clk);
    cfgStart = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (doneN == 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(doneN != 0, req, "done seen", 64'(doneN), 64'd1);
    repeat (3) @(negedge clk);
    srcOn = 1'b0;
  endtask

  function automatic int memMiss(input logic [31:0] addr, input int count, input logic [15:0] base);
    int miss = 0;
    for (int a = int'(addr) - 4; a < int'(addr) + 2 * count + 4; a++) begin
      logic [7:0] expB;
      int rel = a - int'(addr);
      logic [15:0] hw;
      hw = base + 16'(rel / 2);
      if (rel < 0 || rel >= 2 * count) expB = 8'h00;
      else expB = (rel % 2 == 0) ? hw[7:0] : hw[15:8];
      if (mem[13'(a)] != expB) miss++;
    end
    return miss;
  endfunction

  task automatic tResetState();
    chk(inReady == 1'b0 && awValid == 1'b0 && wValid == 1'b0, "R7", "idle handshakes",
        {61'd0, inReady, awValid, wValid}, 64'd0);
    chk(done == 1'b0 && err == 1'b0 && busy == 1'b0, "R8", "idle status",
        {61'd0, done, err, busy}, 64'd0);
  endtask

  task automatic tAligned();
    startXfer(32'h100, 8, 16'hA000);
    waitDone("R5");
    chk({mem[13'h103], mem[13'h102], mem[13'h101], mem[13'h100]} == 32'hA001_A000,
        "R1", "lane order", {mem[13'h103], mem[13'h102], mem[13'h101], mem[13'h100]}, 64'hA001A000);
    chk(memMiss(32'h100, 8, 16'hA000) == 0, "R1", "memory image", 64'(memMiss(32'h100, 8, 16'hA000)), 0);
    chk(awN == 1 && awLenLog[0] == 8'd3, "R5", "single 4-beat burst", {32'(awN), 24'd0, awLenLog[0]}, {32'd1, 32'd3});
    chk(badAw == 0, "R2", "size/type/alignment", 64'(badAw), 0);
  endtask

  task automatic tMisStart();
    startXfer(32'h202, 7, 16'hB000);
    waitDone("R3");
    chk(firstStrb == 4'b1100, "R3", "first strobe", 64'(firstStrb), 64'hC);
    chk(lastStrb == 4'b1111, "R4", "even-end last strobe", 64'(lastStrb), 64'hF);
    chk(awN == 1 && awLenLog[0] == 8'd3 && awAddrLog[0] == 32'h200, "R5", "beat count",
        {32'(awN), 24'd0, awLenLog[0]}, {32'd1, 32'd3});
    chk(memMiss(32'h202, 7, 16'hB000) == 0, "R3", "memory image", 64'(memMiss(32'h202, 7, 16'hB000)), 0);
  endtask

  task automatic tOddEnd();
    startXfer(32'h300, 5, 16'hC000);
    waitDone("R4");
    chk(firstStrb == 4'b1111 && lastStrb == 4'b0011, "R4", "first/last strobe",
        {firstStrb, lastStrb}, 64'hF3);
    chk(wBeats == 3, "R5", "beat total", 64'(wBeats), 3);
    chk(memMiss(32'h300, 5, 16'hC000) == 0, "R4", "memory image", 64'(memMiss(32'h300, 5, 16'hC000)), 0);
  endtask

  task automatic tLongWithWStall();
    wStall = 1'b1;
    startXfer(32'h400, 40, 16'hD000);
    waitDone("R5");
    wStall = 1'b0;
    chk(awN == 2 && awLenLog[0] == 8'd15 && awLenLog[1] == 8'd3, "R5", "split 16+4",
        {32'(awN), awLenLog[0], awLenLog[1]}, {32'd2, 8'd15, 8'd3});
    chk(awAddrLog[1] == 32'h440, "R5", "second burst address", 64'(awAddrLog[1]), 64'h440);
    chk(memMiss(32'h400, 40, 16'hD000) == 0, "R10", "memory under data stall",
        64'(memMiss(32'h400, 40, 16'hD000)), 0);
  endtask

  task automatic tBufferFull();
    awStall = 1'b1;
    startXfer(32'h500, 64, 16'hE000);
    repeat (80) @(negedge clk);
    chk(inReady == 1'b0, "R7", "ready low when full", 64'(inReady), 0);
    chk(srcIdx == 32, "R7", "halfwords accepted", 64'(srcIdx), 32);
    chk(awValid == 1'b1 && awAddr == 32'h500 && awLen == 8'd15, "R10", "address held",
        {awValid, awLen, awAddr}, {1'b1, 8'd15, 32'h500});
    awStall = 1'b0;
    waitDone("R7");
    chk(memMiss(32'h500, 64, 16'hE000) == 0, "R7", "memory image", 64'(memMiss(32'h500, 64, 16'hE000)), 0);
  endtask

  task automatic tPageEdge();
    startXfer(32'hFF8, 16, 16'h1200);
    waitDone("R6");
    chk(awN == 2 && awLenLog[0] == 8'd1 && awLenLog[1] == 8'd5, "R6", "split at page",
        {32'(awN), awLenLog[0], awLenLog[1]}, {32'd2, 8'd1, 8'd5});
    chk(awAddrLog[1] == 32'h1000, "R6", "burst after edge", 64'(awAddrLog[1]), 64'h1000);
    chk(memMiss(32'hFF8, 16, 16'h1200) == 0, "R6", "memory image", 64'(memMiss(32'hFF8, 16, 16'h1200)), 0);
  endtask

  task automatic tErrorFlag();
    errFirst = 1'b1;
    startXfer(32'h600, 40, 16'h3300);
    waitDone("R8");
    errFirst = 1'b0;
    chk(err == 1'b1, "R8", "error latched", 64'(err), 1);
    chk(doneN == 1 && bDone == 2, "R8", "single done after both responses",
        {32'(doneN), 32'(bDone)}, {32'd1, 32'd2});
    startXfer(32'h700, 4, 16'h4400);
    waitDone("R8");
    chk(err == 1'b0, "R8", "error cleared by start", 64'(err), 0);
  endtask

  task automatic tZeroCount();
    startXfer(32'h800, 0, 16'h0);
    waitDone("R9");
    chk(awN == 0 && doneN == 1, "R9", "no address, one done", {32'(awN), 32'(doneN)}, {32'd0, 32'd1});
    chk(busy == 1'b0, "R9", "back to idle", 64'(busy), 0);
  endtask

  initial begin
    rstN = 1'b0; cfgStart = 1'b0; cfgAddr = '0; cfgCount = '0;
    repeat (4) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tAligned();
    tMisStart();
    tOddEnd();
    tLongWithWStall();
    tBufferFull();
    tPageEdge();
    tErrorFlag();
    tZeroCount();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // watchdog
  always @(negedge clk) begin
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule